// File: doc/BRIEF.md
# I2C Line-Toggle Register Port

This peripheral gives software direct control of the two wires of an I2C bus. It holds one output bit for the clock line and one for the data line. Both pads are open-drain: a bit of 0 pulls its line low, and a bit of 1 releases it so the external pull-up takes the line high. Software produces start and stop conditions, data bits and acknowledges by changing these bits one at a time. The block itself does no protocol sequencing.

Two write offsets change the bits. Offset 0x0 sets bits, and offset 0x4 clears bits, so one store can move one line without touching the other. The data line comes in through a two-flop synchronizer. Its synchronized level is latched on every write strobe and held until the next write. A status read at offset 0x0 returns that latched data level together with the driven clock bit.

Register accesses take one cycle. Read data is registered and appears one clock after the read strobe. The block decodes a 4 KiB address window.

Top module: `bbi2c_port`

## Requirements
- R1: While `rst_n` is low, the output bits become 2'b11 at each clock edge, so both pads are released. At the same edges `bus_rdata` becomes 0 and the latched data level becomes 1.
- R2: A write strobe at address 0x000 ORs `bus_wdata` into the output bits. Clock is bit 0 and data is bit 1. A 0 in the write data leaves its bit unchanged.
- R3: A write strobe at address 0x004 clears each output bit whose `bus_wdata` bit is 1. Bits with a 0 in the write data are left unchanged.
- R4: A write strobe at any address other than 0x000 or 0x004 leaves the output bits unchanged. This includes misaligned byte addresses such as 0x005.
- R5: `scl_pull_n` equals output bit 0 and `sda_pull_n` equals output bit 1, from the clock edge that updates the bits onward. A value of 0 pulls the line low.
- R6: A read strobe at address 0x000 loads `bus_rdata` at that clock edge. Bit 0 holds the clock output bit, bit 1 holds the latched data-line level, and all higher bits are 0.
- R7: A read strobe at any address other than 0x000 loads `bus_rdata` with all ones.
- R8: At each write strobe, valid or not, the block latches the data-line level from `sda_in` after two synchronizer flops. It keeps that level, ignoring later changes of `sda_in`, until the next write strobe.
- R9: Without a read strobe, `bus_rdata` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W (12) | Byte address within the window |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 2 | Write data; bit 0 is clock, bit 1 is data |
| bus_rdata | output | DATA_W (32) | Registered read data |
| scl_pull_n | output | 1 | Clock pad pull-down enable, active low |
| sda_pull_n | output | 1 | Data pad pull-down enable, active low |
| sda_in | input | 1 | Sampled level of the data line |

## Verification
The main function is driven through a walk of writes and reads.

- Setting and clearing single bits, both bits and no bits shows whether the set and clear offsets touch only the bits they name.
- Stores to unused and misaligned offsets separate a full address compare from a partial one.
- Status reads taken between these writes show that bit 0 follows the driven clock bit and not the data bit.
- The data line is then pulled low and released with no write in between, and again with writes. This separates a level held from the last write from a live sample.
- A mid-run reset confirms that the bus returns to idle.

// File: rtl/bbi2c_pkg.sv
// Package: shared constants and types for the line-toggle register port.
// Assumes byte addressing and a single register per offset.
package bbi2c_pkg;
    localparam int NLINES   = 2;
    localparam int SCL_BIT  = 0;
    localparam int SDA_BIT  = 1;
    localparam int SET_OFS  = 'h0;
    localparam int CLR_OFS  = 'h4;
    localparam int STAT_OFS = 'h0;

    typedef enum logic [1:0] {
        WK_NONE = 2'd0,
        WK_SET  = 2'd1,
        WK_CLR  = 2'd2
    } wr_kind_e;
endpackage

// File: rtl/bbi2c_decode.sv
// Module: decodes the byte address into the write action and the read selection.
// Assumes a full compare over all ADDR_W bits; every other offset is unused.
module bbi2c_decode
    import bbi2c_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output wr_kind_e          wr_kind,
    output logic              rd_status
);
    localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(SET_OFS);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(CLR_OFS);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);

    // Purpose: select the write action for the offset.
    always_comb begin
        if (addr == A_SET)      wr_kind = WK_SET;
        else if (addr == A_CLR) wr_kind = WK_CLR;
        else                    wr_kind = WK_NONE;
    end

    // Purpose: flag the only readable offset.
    always_comb rd_status = (addr == A_STAT);
endmodule

// File: rtl/bbi2c_outreg.sv
// Module: holds the line output bits, updated by set and clear writes.
// Assumes at most one write per cycle; reset value releases both lines.
module bbi2c_outreg
    import bbi2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  wr_kind_e          wr_kind,
    input  logic [NLINES-1:0] wdata,
    output logic [NLINES-1:0] lines_q
);
    logic [NLINES-1:0] lines_d;

    // Purpose: compute the next output bits for the current write.
    always_comb begin
        lines_d = lines_q;
        if (wr) begin
            case (wr_kind)
                WK_SET:  lines_d = lines_q | wdata;
                WK_CLR:  lines_d = lines_q & ~wdata;
                default: lines_d = lines_q;
            endcase
        end
    end

    // Purpose: register the output bits; reset releases the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) lines_q <= '1;
        else        lines_q <= lines_d;
    end

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> lines_q == '1); // R1
    AST_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wr_kind == WK_SET) |=> ((lines_q & $past(wdata)) == $past(wdata))); // R2
    AST_SET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wr_kind == WK_SET) |=> ((lines_q & $past(lines_q)) == $past(lines_q))); // R2
    AST_CLR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wr_kind == WK_CLR) |=> ((lines_q & $past(wdata)) == '0)); // R3
    AST_CLR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wr_kind == WK_CLR) |=> ((lines_q | $past(wdata)) == ($past(lines_q) | $past(wdata)))); // R3
    AST_BAD_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr || wr_kind == WK_NONE) |=> $stable(lines_q)); // R4
endmodule

// File: rtl/bbi2c_sync.sv
// Module: multi-stage synchronizer for an asynchronous input level.
// Assumes STAGES >= 2; all stages reset to RST_VAL.
module bbi2c_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // Purpose: first capture of the asynchronous level.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= RST_VAL;
                    else        chain[0] <= d_async;
                end
            end else begin : g_next
                // Purpose: settle the level through a further stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= RST_VAL;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/bbi2c_rdpath.sv
// Module: latches the data-line level on writes and registers read data.
// Assumes sda_sync is already synchronized to clk.
module bbi2c_rdpath #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  logic              rd_status,
    input  logic              scl_bit,
    input  logic              sda_sync,
    output logic [DATA_W-1:0] rdata
);
    localparam int PAD_W = DATA_W - 2;

    logic sda_held;

    // Purpose: take a new data-line sample on every write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)  sda_held <= 1'b1;
        else if (wr) sda_held <= sda_sync;
    end

    // Purpose: register the read result on a read strobe, else hold it.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else if (rd) begin
            if (rd_status) rdata <= {{PAD_W{1'b0}}, sda_held, scl_bit};
            else           rdata <= '1;
        end
    end

    AST_RESET_RDATA: assert property (@(posedge clk) !rst_n |=> rdata == '0); // R1
    AST_STAT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && rd_status) |=> rdata[DATA_W-1:2] == '0); // R6
    AST_STAT_SCL: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && rd_status) |=> rdata[0] == $past(scl_bit)); // R6
    AST_BAD_RD_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !rd_status) |=> rdata == '1); // R7
    AST_SDA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(sda_held)); // R8
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rdata)); // R9
endmodule

// File: rtl/bbi2c_port.sv
// Module: top of the line-toggle register port; software drives the clock and
// data lines through set/clear writes and reads back the clock bit and data level.
// Assumes single-cycle strobes, open-drain pads and an external pull-up on each line.
module bbi2c_port
    import bbi2c_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [NLINES-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              scl_pull_n,
    output logic              sda_pull_n,
    input  logic              sda_in
);
    wr_kind_e          wr_kind;
    logic              rd_status;
    logic [NLINES-1:0] lines_q;
    logic              sda_sync;

    bbi2c_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr      (bus_addr),
        .wr_kind   (wr_kind),
        .rd_status (rd_status)
    );

    bbi2c_outreg u_outreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (bus_wr),
        .wr_kind (wr_kind),
        .wdata   (bus_wdata),
        .lines_q (lines_q)
    );

    bbi2c_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (sda_in),
        .q_sync  (sda_sync)
    );

    bbi2c_rdpath #(.DATA_W(DATA_W)) u_rdpath (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (bus_wr),
        .rd        (bus_rd),
        .rd_status (rd_status),
        .scl_bit   (lines_q[SCL_BIT]),
        .sda_sync  (sda_sync),
        .rdata     (bus_rdata)
    );

    // Purpose: a 0 bit enables the pull-down, a 1 bit releases the line.
    assign scl_pull_n = lines_q[SCL_BIT];
    assign sda_pull_n = lines_q[SDA_BIT];

    AST_PADS_RESET: assert property (@(posedge clk) !rst_n |=> (scl_pull_n && sda_pull_n)); // R5
    AST_PADS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ($stable(scl_pull_n) && $stable(sda_pull_n))); // R5
endmodule

// File: tb/bbi2c_port_tb_top.sv
// Bench: vector walk over set/clear/status accesses, then directed tests.
module bbi2c_port_tb_top;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    typedef struct packed {
        logic        rd;
        logic [11:0] addr;
        logic [1:0]  wd;
        logic [31:0] exp;
    } vec_t;

    // Writes: exp = expected {sda_pull_n, scl_pull_n}. Reads: exp = expected rdata.
    localparam int NVEC = 15;
    localparam vec_t VECS [NVEC] = '{
        {1'b0, 12'h004, 2'b01, 32'h0000_0002},  // R3 clear clock bit
        {1'b1, 12'h000, 2'b00, 32'h0000_0002},  // R6 status
        {1'b0, 12'h004, 2'b10, 32'h0000_0000},  // R3 clear data bit
        {1'b1, 12'h000, 2'b00, 32'h0000_0002},  // R6
        {1'b0, 12'h000, 2'b01, 32'h0000_0001},  // R2 set clock bit
        {1'b1, 12'h000, 2'b00, 32'h0000_0003},  // R6
        {1'b0, 12'h008, 2'b10, 32'h0000_0001},  // R4 unused offset
        {1'b0, 12'h000, 2'b00, 32'h0000_0001},  // R2 zero data
        {1'b1, 12'h004, 2'b00, 32'hFFFF_FFFF},  // R7
        {1'b0, 12'h000, 2'b10, 32'h0000_0003},  // R2 set data bit
        {1'b0, 12'h004, 2'b11, 32'h0000_0000},  // R3 clear both
        {1'b1, 12'hFFC, 2'b00, 32'hFFFF_FFFF},  // R7
        {1'b0, 12'h000, 2'b11, 32'h0000_0003},  // R2 set both
        {1'b1, 12'h000, 2'b00, 32'h0000_0003},  // R6
        {1'b0, 12'h005, 2'b11, 32'h0000_0003}   // R4 misaligned
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [1:0]        bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              scl_pull_n;
    logic              sda_pull_n;
    logic              sda_in = 1'b1;

    int n_checks = 0;
    int n_fails  = 0;
    logic [1:0] pads_exp = 2'b11;

    always #4 clk = ~clk;

    bbi2c_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .scl_pull_n (scl_pull_n),
        .sda_pull_n (sda_pull_n),
        .sda_in     (sda_in)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [11:0] a, input logic [1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_read(input logic [11:0] a);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks + 1, n_fails);
        $finish;
    end

    initial begin
        idle(3);
        // R1: reset state
        check("R1 pads at reset", {30'd0, sda_pull_n, scl_pull_n}, 32'h3);
        check("R1 rdata at reset", bus_rdata, 32'h0);
        rst_n = 1'b1;
        idle(3);

        // Vector walk
        for (int i = 0; i < NVEC; i++) begin
            if (VECS[i].rd) begin
                do_read(VECS[i].addr);
                check($sformatf("R6/R7 read vec %0d", i), bus_rdata, VECS[i].exp);
                check($sformatf("R5 pads after read vec %0d", i),
                      {30'd0, sda_pull_n, scl_pull_n}, {30'd0, pads_exp});
            end else begin
                do_write(VECS[i].addr, VECS[i].wd);
                pads_exp = VECS[i].exp[1:0];
                check($sformatf("R2/R3/R4/R5 pads vec %0d", i),
                      {30'd0, sda_pull_n, scl_pull_n}, VECS[i].exp);
            end
        end

        // R9: read data holds with no strobe
        idle(5);
        check("R9 rdata held", bus_rdata, 32'h3);

        // R8: data level change without a write is not seen
        sda_in = 1'b0;
        idle(4);
        do_read(12'h000);
        check("R8 level held without write", bus_rdata, 32'h3);

        // R8: a write at an unused offset still latches the level
        do_write(12'h008, 2'b00);
        do_read(12'h000);
        check("R8 level latched on write", bus_rdata, 32'h1);
        check("R4 pads after unused write", {30'd0, sda_pull_n, scl_pull_n}, 32'h3);

        // R8: release line, no write, level stays low
        sda_in = 1'b1;
        idle(4);
        do_read(12'h000);
        check("R8 low level kept", bus_rdata, 32'h1);

        // R8/R6: clear clock then read, fresh latch
        do_write(12'h004, 2'b01);
        do_read(12'h000);
        check("R6 clock low, data high", bus_rdata, 32'h2);

        // R1: mid-run reset releases the bus
        do_write(12'h004, 2'b10);
        check("R5 both pulled", {30'd0, sda_pull_n, scl_pull_n}, 32'h0);
        @(negedge clk);
        rst_n = 1'b0;
        idle(2);
        check("R1 pads after reset", {30'd0, sda_pull_n, scl_pull_n}, 32'h3);
        check("R1 rdata after reset", bus_rdata, 32'h0);
        rst_n = 1'b1;
        idle(2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule